// File: doc/BRIEF.md
# I2C Pointer-Addressed Register Target

This block is a bus target for a two-wire serial bus. It holds four 16-bit registers and a two-bit pointer that picks one of them. It watches the clock and data lines through synchronizers. It drives nothing but an enable that pulls the data line low, so the surrounding pad logic builds the open-drain output. It never drives the clock line.

A controller writes by sending the address byte with the direction bit clear, then a pointer byte. It may then send two data bytes, high byte first, which land in the register that the pointer selects. A read sends the address byte with the direction bit set. The target then returns the register that the last pointer byte selected, high byte first, with no pointer resent.

The conversion register can be read from the bus but only loaded from a parallel input. The other three registers are exposed to the surrounding logic, together with a one-cycle update strobe and the index of the register that changed.

Top module: `i2c_ptr_target`

## Requirements
- R1: After reset the registers hold conversion 0x0000, config 0x8583, low threshold 0x8000 and high threshold 0x7FFF, and the SDA pull-down enable is off.
- R2: With the default 7-bit address 1001000b, the address bytes 0x90 (write) and 0x91 (read) are acknowledged by pulling SDA low in the ninth clock. Any other address is not acknowledged, and the target ignores the rest of that transaction.
- R3: In a write, the byte after the address is the pointer byte. Its bits [1:0] select 00 conversion, 01 config, 10 low threshold, 11 high threshold. Every byte of an addressed write is acknowledged.
- R4: The third and fourth bytes of a write form the new register value, high byte first. The value is stored when the fourth byte ends, and the update strobe pulses for one cycle with the register index on the select output.
- R5: A write that carries only the address and the pointer byte changes the pointer and no register, and it raises no strobe.
- R6: A read returns the selected register high byte first, then low byte. Reads that follow reuse the pointer without resending it. If the controller keeps acknowledging, the high and low bytes repeat in turn.
- R7: When the controller does not acknowledge a byte sent by the target, the target leaves SDA released until the next START.
- R8: A START or STOP in the middle of a byte aborts that byte and discards a partly received data write. A START returns the target to address recognition.
- R9: The conversion register loads from the parallel input when the load input is high. A bus write to pointer 00 is acknowledged and changes nothing.
- R10: The SDA enable changes only while SCL is low, apart from the release forced by a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain enable) |
| conv_load_i | input | 1 | Loads the conversion register from conv_data_i |
| conv_data_i | input | 16 | Parallel value for the conversion register |
| conv_o | output | 16 | Conversion register |
| cfg_o | output | 16 | Config register |
| lo_thr_o | output | 16 | Low threshold register |
| hi_thr_o | output | 16 | High threshold register |
| wr_stb_o | output | 1 | One-cycle pulse when a bus write updates a register |
| wr_sel_o | output | 2 | Index of the register that the write updated |

## Verification
The assertions check, on every cycle, the following:
- the target stays quiet while idle;
- a STOP releases the line and a START restarts address recognition;
- the data enable moves only after a clock fall;
- a missing acknowledge ends transmission;
- the conversion register never changes without its load;
- a strobed write really lands in the register it names.

Only the bench scenarios can show the rest:
- the bytes carried in a transaction come out in the right order;
- a mismatched address leaves every register alone;
- the pointer persists across separate transactions;
- an aborted data byte leaves no trace, as seen by reading the register back over the bus.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  localparam int REG_W = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RX,
    PH_ACK,
    PH_TX,
    PH_TXACK
  } phase_t;

  // Address byte carries the 7-bit target address above the direction bit.
  function automatic logic addr_hit(input logic [7:0] b, input logic [6:0] a7);
    return b[7:1] == a7;
  endfunction

  // Byte sent next in a read: low half after the high half, and back again.
  function automatic logic [7:0] tx_pick(input logic [REG_W-1:0] w, input logic low_half);
    return low_half ? w[7:0] : w[15:8];
  endfunction
endpackage

// File: rtl/i2ct_bus_sampler.sv
module i2ct_bus_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign scl_s     = scl_ff[SYNC_STAGES-1];
  assign sda_s     = sda_ff[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2ct_reg_bank.sv
module i2ct_reg_bank
  import i2ct_pkg::*;
#(
  parameter logic [REG_W-1:0] CONV_RST = 16'h0000,
  parameter logic [REG_W-1:0] CFG_RST  = 16'h8583,
  parameter logic [REG_W-1:0] LO_RST   = 16'h8000,
  parameter logic [REG_W-1:0] HI_RST   = 16'h7FFF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en_i,
  input  logic [1:0]            wr_sel_i,
  input  logic [REG_W-1:0]      wr_data_i,
  input  logic                  conv_load_i,
  input  logic [REG_W-1:0]      conv_data_i,
  output logic [3:0][REG_W-1:0] regs_o
);
  localparam logic [3:0][REG_W-1:0] RST_VALS = {HI_RST, LO_RST, CFG_RST, CONV_RST};

  logic [REG_W-1:0] regs_q [4];

  for (genvar i = 0; i < 4; i++) begin : g_reg
    if (i == 0) begin : g_conv
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           regs_q[i] <= RST_VALS[i];
        else if (conv_load_i) regs_q[i] <= conv_data_i;
      end
      AST_CONV_BUS_IMMUNE: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_load_i |=> $stable(regs_o[0])); // R9
    end else begin : g_bus
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   regs_q[i] <= RST_VALS[i];
        else if (wr_en_i && wr_sel_i == 2'(i))        regs_q[i] <= wr_data_i;
      end
    end
    assign regs_o[i] = regs_q[i];
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && wr_sel_i != 2'd0 |=> regs_o[$past(wr_sel_i)] == $past(wr_data_i)); // R4
endmodule

// File: rtl/i2ct_link.sv
module i2ct_link
  import i2ct_pkg::*;
#(
  parameter logic [6:0] ADDR7 = 7'h48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [REG_W-1:0] rd_word_i,
  output logic             sda_oe_o,
  output logic [1:0]       ptr_o,
  output logic             wr_en_o,
  output logic [REG_W-1:0] wr_data_o
);
  phase_t           ph;
  logic [3:0]       bitcnt;
  logic [7:0]       sh;
  logic [2:0]       bidx;
  logic             rw;
  logic [7:0]       msb_hold;
  logic [REG_W-1:0] tx_word;
  logic             tx_low;
  logic             ack_ok;
  logic             oe;
  logic [7:0]       nxt_byte;

  assign nxt_byte = tx_pick(tx_word, ~tx_low);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_IDLE; bitcnt <= '0; sh <= '0; bidx <= '0; rw <= 1'b0;
      msb_hold <= '0; tx_word <= '0; tx_low <= 1'b0; ack_ok <= 1'b0;
      oe <= 1'b0; ptr_o <= '0; wr_en_o <= 1'b0; wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (stop_det) begin
        ph <= PH_IDLE;
        oe <= 1'b0;
      end else if (start_det) begin
        ph     <= PH_RX;
        bitcnt <= '0;
        bidx   <= '0;
        oe     <= 1'b0;
      end else begin
        unique case (ph)
          PH_RX: begin
            if (scl_rise && bitcnt < 4'd8) begin
              sh     <= {sh[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              bitcnt <= '0;
              if (bidx == 3'd0) begin
                if (addr_hit(sh, ADDR7)) begin
                  rw      <= sh[0];
                  oe      <= 1'b1;
                  ph      <= PH_ACK;
                  tx_word <= rd_word_i;
                end else begin
                  ph <= PH_IDLE;
                end
              end else begin
                oe <= 1'b1;
                ph <= PH_ACK;
                if (bidx == 3'd1) ptr_o <= sh[1:0];
                if (bidx == 3'd2) msb_hold <= sh;
                if (bidx == 3'd3) begin
                  wr_en_o   <= (ptr_o != 2'd0);
                  wr_data_o <= {msb_hold, sh};
                end
              end
            end
          end
          PH_ACK: begin
            if (scl_fall) begin
              if (rw && bidx == 3'd0) begin
                oe     <= ~tx_word[15];
                sh     <= {tx_word[14:8], 1'b0};
                bitcnt <= 4'd1;
                tx_low <= 1'b0;
                ph     <= PH_TX;
              end else begin
                oe <= 1'b0;
                ph <= PH_RX;
                if (bidx != 3'd4) bidx <= bidx + 3'd1;
              end
            end
          end
          PH_TX: begin
            if (scl_fall) begin
              if (bitcnt < 4'd8) begin
                oe     <= ~sh[7];
                sh     <= {sh[6:0], 1'b0};
                bitcnt <= bitcnt + 4'd1;
              end else begin
                oe     <= 1'b0;
                ack_ok <= 1'b0;
                ph     <= PH_TXACK;
              end
            end
          end
          PH_TXACK: begin
            if (scl_rise) begin
              ack_ok <= ~sda_s;
            end else if (scl_fall) begin
              if (ack_ok) begin
                oe     <= ~nxt_byte[7];
                sh     <= {nxt_byte[6:0], 1'b0};
                bitcnt <= 4'd1;
                tx_low <= ~tx_low;
                ph     <= PH_TX;
              end else begin
                ph <= PH_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o = oe;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ph == PH_IDLE |-> !sda_oe_o); // R2
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (ph == PH_IDLE && !sda_oe_o)); // R8
  AST_START_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
    start_det && !stop_det |=> (ph == PH_RX && bidx == 3'd0 && !sda_oe_o)); // R8
  AST_OE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> $past(scl_fall || start_det || stop_det)); // R10
  AST_NACK_ENDS_TX: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_TXACK && scl_fall && !ack_ok && !start_det && !stop_det) |=> ph == PH_IDLE); // R7
endmodule

// File: rtl/i2c_ptr_target.sv
module i2c_ptr_target
  import i2ct_pkg::*;
#(
  parameter logic [6:0]       ADDR7       = 7'h48,
  parameter int               SYNC_STAGES = 2,
  parameter logic [REG_W-1:0] CONV_RST    = 16'h0000,
  parameter logic [REG_W-1:0] CFG_RST     = 16'h8583,
  parameter logic [REG_W-1:0] LO_RST      = 16'h8000,
  parameter logic [REG_W-1:0] HI_RST      = 16'h7FFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  input  logic             conv_load_i,
  input  logic [REG_W-1:0] conv_data_i,
  output logic [REG_W-1:0] conv_o,
  output logic [REG_W-1:0] cfg_o,
  output logic [REG_W-1:0] lo_thr_o,
  output logic [REG_W-1:0] hi_thr_o,
  output logic             wr_stb_o,
  output logic [1:0]       wr_sel_o
);
  logic                  sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [1:0]            ptr;
  logic                  wr_en;
  logic [REG_W-1:0]      wr_data;
  logic [3:0][REG_W-1:0] regs;

  i2ct_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
    .clk, .rst_n, .scl_i, .sda_i, .sda_s, .scl_rise, .scl_fall, .start_det, .stop_det
  );

  i2ct_link #(.ADDR7(ADDR7)) u_link (
    .clk, .rst_n, .sda_s, .scl_rise, .scl_fall, .start_det, .stop_det,
    .rd_word_i(regs[ptr]), .sda_oe_o, .ptr_o(ptr), .wr_en_o(wr_en), .wr_data_o(wr_data)
  );

  i2ct_reg_bank #(
    .CONV_RST(CONV_RST), .CFG_RST(CFG_RST), .LO_RST(LO_RST), .HI_RST(HI_RST)
  ) u_bank (
    .clk, .rst_n, .wr_en_i(wr_en), .wr_sel_i(ptr), .wr_data_i(wr_data),
    .conv_load_i, .conv_data_i, .regs_o(regs)
  );

  assign conv_o   = regs[0];
  assign cfg_o    = regs[1];
  assign lo_thr_o = regs[2];
  assign hi_thr_o = regs[3];
  assign wr_stb_o = wr_en;
  assign wr_sel_o = ptr;
endmodule

// File: tb/sim_i2c_ptr_target.sv
module sim_i2c_ptr_target;
  localparam int CLK_PERIOD = 10;
  localparam int HB = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_drv = 1'b1, tb_pull = 1'b0;
  logic conv_load = 1'b0;
  logic [15:0] conv_data = '0;
  logic sda_oe;
  logic [15:0] conv_o, cfg_o, lo_o, hi_o;
  logic wr_stb;
  logic [1:0] wr_sel;
  wire sda_line = ~(tb_pull | sda_oe);

  int checks = 0, fails = 0, stb_cnt = 0, r10_viol = 0;
  bit done = 0;
  logic [15:0] model [4];
  logic prev_oe = 1'b0, prev_scl = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_ptr_target u0 (
    .clk, .rst_n, .scl_i(scl_drv), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .conv_load_i(conv_load), .conv_data_i(conv_data), .conv_o, .cfg_o,
    .lo_thr_o(lo_o), .hi_thr_o(hi_o), .wr_stb_o(wr_stb), .wr_sel_o(wr_sel)
  );

  always @(posedge clk) begin
    if (rst_n && wr_stb) stb_cnt++;
    if (rst_n && sda_oe !== prev_oe && prev_scl && scl_drv) r10_viol++;
    prev_oe  <= sda_oe;
    prev_scl <= scl_drv;
  end

  function automatic logic [7:0] half_of(input logic [15:0] w, input int k);
    return (k % 2 == 0) ? w >> 8 : w & 16'h00FF;
  endfunction

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    tb_pull = 0; scl_drv = 1; wclk(HB); tb_pull = 1; wclk(HB); scl_drv = 0; wclk(2);
  endtask
  task automatic bus_rstart();
    tb_pull = 0; wclk(HB); scl_drv = 1; wclk(HB); tb_pull = 1; wclk(HB); scl_drv = 0; wclk(2);
  endtask
  task automatic bus_stop();
    tb_pull = 1; wclk(HB); scl_drv = 1; wclk(HB); tb_pull = 0; wclk(HB);
  endtask
  task automatic send_bit(input logic b);
    tb_pull = ~b; wclk(HB); scl_drv = 1; wclk(HB); scl_drv = 0; wclk(2);
  endtask
  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    tb_pull = 0; wclk(HB); scl_drv = 1; wclk(HB/2); ack = ~sda_line; wclk(HB/2);
    scl_drv = 0; wclk(2);
  endtask
  task automatic rbyte(input logic give_ack, output logic [7:0] b);
    tb_pull = 0;
    for (int i = 7; i >= 0; i--) begin
      wclk(HB); scl_drv = 1; wclk(HB/2); b[i] = sda_line; wclk(HB/2); scl_drv = 0; wclk(2);
    end
    tb_pull = give_ack; wclk(HB); scl_drv = 1; wclk(HB); scl_drv = 0; wclk(2); tb_pull = 0;
  endtask

  task automatic write_reg(input logic [1:0] p, input logic [15:0] v);
    logic a0, a1, a2, a3;
    bus_start(); wbyte(8'h90, a0); wbyte({6'd0, p}, a1);
    wbyte(v[15:8], a2); wbyte(v[7:0], a3); bus_stop();
    chk("R3 write acks", {a0, a1, a2, a3}, 4'hF);
    if (p != 2'd0) model[p] = v;
  endtask
  task automatic set_ptr(input logic [1:0] p);
    logic a0, a1;
    bus_start(); wbyte(8'h90, a0); wbyte({6'd0, p}, a1); bus_stop();
    chk("R5 pointer acks", {a0, a1}, 2'b11);
  endtask
  task automatic read_reg(output logic [15:0] v);
    logic a; logic [7:0] m, l;
    bus_start(); wbyte(8'h91, a); rbyte(1'b1, m); rbyte(1'b0, l); bus_stop();
    chk("R2 read address ack", a, 1'b1);
    v = {m, l};
  endtask
  task automatic check_ports(input string req);
    chk(req, {conv_o, cfg_o}, {model[0], model[1]});
    chk(req, {lo_o, hi_o}, {model[2], model[3]});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, w;
    logic [7:0] b0, b1, b2;
    logic a, a1;
    int s0;
    model[0] = 16'h0000; model[1] = 16'h8583; model[2] = 16'h8000; model[3] = 16'h7FFF;
    void'($urandom(32'd4242));
    wclk(5); rst_n = 1; wclk(5);

    // R1 reset values
    check_ports("R1 reset values");
    chk("R1 sda released", sda_oe, 1'b0);

    // R4 directed write and strobe
    s0 = stb_cnt;
    write_reg(2'd1, 16'h1234);
    check_ports("R4 config write");
    chk("R4 one strobe", stb_cnt - s0, 1);
    chk("R4 strobe select", wr_sel, 2'd1);
    read_reg(v);
    chk("R6 read config", v, 16'h1234);
    read_reg(v);
    chk("R6 pointer reused", v, 16'h1234);

    // R5 pointer-only write
    s0 = stb_cnt;
    set_ptr(2'd3);
    check_ports("R5 no register change");
    chk("R5 no strobe", stb_cnt - s0, 0);
    read_reg(v);
    chk("R5 pointer now high threshold", v, model[3]);

    // R2 address mismatch
    bus_start(); wbyte(8'hA0, a); wbyte(8'h02, a1); wbyte(8'h55, b0[0]); bus_stop();
    chk("R2 mismatch nack", {a, a1}, 2'b00);
    check_ports("R2 mismatch no change");
    bus_start(); wbyte(8'h93, a); bus_stop();
    chk("R2 other read address nack", a, 1'b0);

    // R6 continued read repeats high byte; R7 nack releases bus
    bus_start(); wbyte(8'h91, a); rbyte(1'b1, b0); rbyte(1'b1, b1); rbyte(1'b0, b2);
    chk("R6 third byte repeats high half", {b0, b1, b2}, {half_of(model[3], 0), half_of(model[3], 1), half_of(model[3], 2)});
    rbyte(1'b1, b0);
    chk("R7 released after nack", b0, 8'hFF);
    bus_stop();

    // R8 stop mid data byte
    bus_start(); wbyte(8'h90, a); wbyte(8'h02, a); wbyte(8'h12, a);
    send_bit(1); send_bit(0); send_bit(1); send_bit(1);
    bus_stop();
    check_ports("R8 stop abort discards");
    // R8 repeated start mid byte, then a full write
    bus_start(); wbyte(8'h90, a); wbyte(8'h02, a); wbyte(8'hEE, a);
    send_bit(0); send_bit(1); send_bit(1);
    bus_rstart(); wbyte(8'h90, a); wbyte(8'h03, a1); wbyte(8'hAB, b0[0]); wbyte(8'hCD, b0[1]); bus_stop();
    model[3] = 16'hABCD;
    chk("R8 restart acks", {a, a1, b0[1:0]}, 4'hF);
    check_ports("R8 restart discards partial");

    // R9 conversion load and bus immunity
    for (int k = 0; k < 3; k++) begin
      w = 16'($urandom);
      conv_data = w; conv_load = 1; wclk(1); conv_load = 0; model[0] = w; wclk(1);
      set_ptr(2'd0);
      read_reg(v);
      chk("R9 conversion readback", v, w);
    end
    s0 = stb_cnt;
    write_reg(2'd0, 16'h5A5A);
    chk("R9 bus write ignored", conv_o, model[0]);
    chk("R9 no strobe", stb_cnt - s0, 0);

    // R3 R4 random writes with readback
    for (int k = 0; k < 12; k++) begin
      logic [1:0] p;
      p = 2'(1 + ($urandom % 3));
      w = 16'($urandom);
      write_reg(p, w);
      read_reg(v);
      chk("R3 random readback", v, w);
      check_ports("R4 random ports");
    end
    write_reg(2'd2, 16'h0000);
    read_reg(v);
    chk("R4 zero value", v, 16'h0000);
    write_reg(2'd2, 16'hFFFF);
    read_reg(v);
    chk("R4 all ones", v, 16'hFFFF);

    chk("R10 sda enable moved with scl high", r10_viol, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule